// File: doc/BRIEF.md
# Windowed Clock Frequency Monitor

This block measures how fast a monitored clock runs compared with a reference clock. A window generator in the reference domain counts a programmable number of reference cycles. During each window, a counter in the monitored domain counts ticks of the monitored clock after a selectable pre-divider. When a window closes, the accumulated count is captured and carried back to the reference domain. There it becomes the visible result.

Each new result is compared with two pairs of limits, one for failure and one for warning, and with a saturation ceiling. Any limit that is crossed sets a sticky event flag. Configuration is written through a simple write port in the reference clock domain while the block is disabled. Raising `en` starts measurement. The first window after enable is thrown away, so no check is ever made on a partial count.

Top module: `clk_freq_monitor`

## Requirements
- R1: One window lasts the programmed window value plus one reference cycles. In steady state the result equals (window value + 1) × f_mon / (f_ref × division ratio) whenever that value is an integer.
- R2: The divider code selects the pre-divider ratio: code 2'b00 divides by 1, 2'b01 by 2, 2'b10 by 4, and 2'b11 falls back to divide by 1.
- R3: Every window after the first places its count on `meas_count`. The value stays there until the next window completes.
- R4: `evt_fail` is set when a result is strictly greater than the high fail limit or strictly less than the low fail limit. A result equal to either limit does not set it.
- R5: `evt_warn` is set when a result is strictly greater than the high warning limit or strictly less than the low warning limit.
- R6: The counter stops at the saturation value, so a result never exceeds it. `evt_sat` is set when a result reaches that value.
- R7: The event flags stay set until a write to address 7 clears them. A 1 in bit 0 clears fail, bit 1 clears warn and bit 2 clears sat; a 0 bit leaves its flag unchanged. Disabling the block does not clear the flags.
- R8: Configuration addresses are 0 window, 1 divider code, 2 high fail, 3 low fail, 4 high warn, 5 low warn and 6 saturation. Writes to these addresses while `en` is high are ignored.
- R9: `meas_ready` rises with the first valid result after enable. It returns low one cycle after `en` is sampled low.
- R10: The first window after enable is discarded: `meas_ready` stays low and `meas_count` keeps its previous value.
- R11: After reset `meas_count`, `meas_ready` and all event flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; also clocks the configuration port and the outputs |
| clk_mon | input | 1 | Clock under measurement |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| en | input | 1 | Run enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | DATA_W | Configuration write data |
| meas_count | output | CNT_W | Latest valid window count |
| meas_ready | output | 1 | A valid result is present while enabled |
| evt_fail | output | 1 | Sticky fail-limit event |
| evt_warn | output | 1 | Sticky warning-limit event |
| evt_sat | output | 1 | Sticky saturation event |

## Verification
A window closes W+1 reference cycles after it starts. The close then reaches the outputs after about three monitored cycles plus three reference cycles of synchronizer delay, so the exact cycle of each update depends on the ratio between the clocks. For that reason the bench never samples near an update edge. It checks that the first result is missing at one and a half windows after enable, and it checks the steady result and flags three windows plus 30 cycles after enable. The bench keeps the two clocks phase-locked, with each window a whole number of monitored periods, so every steady-state count is exact. Configuration changes and flag clears happen only after the block has been disabled for ten cycles, and the outputs are checked before the next stimulus.

// File: rtl/cfm_pkg.sv
`timescale 1ns/1ps
package cfm_pkg;
  typedef enum logic [2:0] {
    A_WIN = 3'd0, A_DIV = 3'd1, A_HFAIL = 3'd2, A_LFAIL = 3'd3,
    A_HWARN = 3'd4, A_LWARN = 3'd5, A_SAT = 3'd6, A_CLR = 3'd7
  } cfg_addr_e;

  localparam int EV_FAIL = 0;
  localparam int EV_WARN = 1;
  localparam int EV_SAT  = 2;
  localparam int EV_N    = 3;

  // mask applied to the free-running prescale counter
  function automatic logic [1:0] div_mask(input logic [1:0] code);
    case (code)
      2'b01:   return 2'b01;
      2'b10:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic outside_band(input logic [63:0] v,
                                        input logic [63:0] hi,
                                        input logic [63:0] lo);
    return (v > hi) || (v < lo);
  endfunction

  function automatic logic at_ceiling(input logic [63:0] v,
                                      input logic [63:0] ceil);
    return v >= ceil;
  endfunction
endpackage

// File: rtl/cfm_window_gen.sv
`timescale 1ns/1ps
module cfm_window_gen #(
  parameter int WIN_W = 32
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end,
  output logic             win_tgl
);
  logic [WIN_W-1:0] pos;

  assign win_end = run && (pos == win_len);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      win_tgl <= 1'b0;
    end else if (!run) begin
      pos <= '0;
    end else if (win_end) begin
      pos     <= '0;
      win_tgl <= ~win_tgl;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  // two window ends are never adjacent unless the window is one cycle
  assert_window_gap_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (win_end && win_len != '0) |=> !win_end);
  assert_toggle_on_end_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    win_end |=> (win_tgl != $past(win_tgl)));
endmodule

// File: rtl/cfm_edge_counter.sv
`timescale 1ns/1ps
module cfm_edge_counter
  import cfm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_mon,
  input  logic             rst_n,
  input  logic             run,
  input  logic             win_tgl,
  input  logic [1:0]       div_code,
  input  logic [CNT_W-1:0] sat_lim,
  output logic             cap_tgl,
  output logic [CNT_W-1:0] cap_val
);
  logic             run_s1, run_s2;
  logic             wt_s1, wt_s2, wt_s3;
  logic [1:0]       pre;
  logic             tick;
  logic             cap_ev;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       mask;

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      run_s1 <= 1'b0; run_s2 <= 1'b0;
      wt_s1  <= 1'b0; wt_s2  <= 1'b0; wt_s3 <= 1'b0;
    end else begin
      run_s1 <= run;   run_s2 <= run_s1;
      wt_s1  <= win_tgl; wt_s2 <= wt_s1; wt_s3 <= wt_s2;
    end
  end

  assign cap_ev = wt_s2 ^ wt_s3;
  assign mask   = div_mask(div_code);
  assign tick   = run_s2 && ((pre & mask) == mask);

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n)       pre <= '0;
    else if (!run_s2) pre <= '0;
    else              pre <= pre + 2'd1;
  end

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run_s2) begin
      cnt <= '0;
    end else if (cap_ev) begin
      cnt <= (tick && sat_lim != '0) ? CNT_W'(1) : '0;
    end else if (tick && cnt < sat_lim) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      cap_tgl <= 1'b0;
      cap_val <= '0;
    end else if (cap_ev) begin
      cap_tgl <= ~cap_tgl;
      cap_val <= cnt;
    end
  end

  assert_div2_alternate_R2: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (tick && div_code == 2'b01 && run_s1) |=> !tick);
  assert_hold_at_ceiling_R6: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (run_s2 && run_s1 && !cap_ev && cnt >= sat_lim) |=> (cnt == $past(cnt)));
  assert_capture_toggles_R3: assert property (@(posedge clk_mon) disable iff (!rst_n)
    cap_ev |=> (cap_tgl != $past(cap_tgl)));
endmodule

// File: rtl/cfm_result_sync.sv
`timescale 1ns/1ps
module cfm_result_sync
  import cfm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cap_tgl,
  input  logic [CNT_W-1:0] cap_val,
  input  logic [CNT_W-1:0] hi_fail,
  input  logic [CNT_W-1:0] lo_fail,
  input  logic [CNT_W-1:0] hi_warn,
  input  logic [CNT_W-1:0] lo_warn,
  input  logic [CNT_W-1:0] sat_lim,
  input  logic [EV_N-1:0]  clr,
  output logic [CNT_W-1:0] result,
  output logic             ready,
  output logic [EV_N-1:0]  flags
);
  logic            ct_s1, ct_s2, ct_s3;
  logic            new_ev, primed, valid_ev;
  logic [EV_N-1:0] hit;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ct_s1 <= 1'b0; ct_s2 <= 1'b0; ct_s3 <= 1'b0;
    end else begin
      ct_s1 <= cap_tgl; ct_s2 <= ct_s1; ct_s3 <= ct_s2;
    end
  end

  assign new_ev   = ct_s2 ^ ct_s3;
  assign valid_ev = run && new_ev && primed;

  always_comb begin
    hit          = '0;
    hit[EV_FAIL] = outside_band(64'(cap_val), 64'(hi_fail), 64'(lo_fail));
    hit[EV_WARN] = outside_band(64'(cap_val), 64'(hi_warn), 64'(lo_warn));
    hit[EV_SAT]  = at_ceiling(64'(cap_val), 64'(sat_lim));
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      ready  <= 1'b0;
      result <= '0;
    end else if (!run) begin
      primed <= 1'b0;
      ready  <= 1'b0;
    end else if (new_ev) begin
      primed <= 1'b1;
      if (primed) begin
        ready  <= 1'b1;
        result <= cap_val;
      end
    end
  end

  for (genvar i = 0; i < EV_N; i++) begin : g_flag
    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)        flags[i] <= 1'b0;
      else if (valid_ev && hit[i]) flags[i] <= 1'b1;
      else if (clr[i])   flags[i] <= 1'b0;
    end
    assert_flag_sticky_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]);
  end

  assert_first_discard_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run && new_ev && !primed) |=> ($stable(result) && !ready));
  assert_ready_source_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(ready) |-> $past(valid_ev));
  assert_ready_drop_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !run |=> !ready);
endmodule

// File: rtl/clk_freq_monitor.sv
`timescale 1ns/1ps
module clk_freq_monitor
  import cfm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIN_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_ref,
  input  logic              clk_mon,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]  meas_count,
  output logic              meas_ready,
  output logic              evt_fail,
  output logic              evt_warn,
  output logic              evt_sat
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [WIN_W-1:0] win_len;
  logic [1:0]       div_code;
  logic [CNT_W-1:0] hi_fail, lo_fail, hi_warn, lo_warn, sat_lim;
  logic [EV_N-1:0]  clr, flags;
  logic             win_end, win_tgl, cap_tgl;
  logic [CNT_W-1:0] cap_val;
  logic             cfg_open;

  assign cfg_open = cfg_we && !en;
  assign clr = (cfg_we && cfg_addr_e'(cfg_addr) == A_CLR) ? cfg_wdata[EV_N-1:0] : '0;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      win_len  <= WIN_W'(255);
      div_code <= 2'b00;
      hi_fail  <= ALL_ONES;
      lo_fail  <= '0;
      hi_warn  <= ALL_ONES;
      lo_warn  <= '0;
      sat_lim  <= ALL_ONES;
    end else if (cfg_open) begin
      case (cfg_addr_e'(cfg_addr))
        A_WIN:   win_len  <= cfg_wdata[WIN_W-1:0];
        A_DIV:   div_code <= cfg_wdata[1:0];
        A_HFAIL: hi_fail  <= cfg_wdata[CNT_W-1:0];
        A_LFAIL: lo_fail  <= cfg_wdata[CNT_W-1:0];
        A_HWARN: hi_warn  <= cfg_wdata[CNT_W-1:0];
        A_LWARN: lo_warn  <= cfg_wdata[CNT_W-1:0];
        A_SAT:   sat_lim  <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  cfm_window_gen #(.WIN_W(WIN_W)) u_win (
    .clk_ref(clk_ref), .rst_n(rst_n), .run(en), .win_len(win_len),
    .win_end(win_end), .win_tgl(win_tgl)
  );

  cfm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_mon(clk_mon), .rst_n(rst_n), .run(en), .win_tgl(win_tgl),
    .div_code(div_code), .sat_lim(sat_lim),
    .cap_tgl(cap_tgl), .cap_val(cap_val)
  );

  cfm_result_sync #(.CNT_W(CNT_W)) u_res (
    .clk_ref(clk_ref), .rst_n(rst_n), .run(en),
    .cap_tgl(cap_tgl), .cap_val(cap_val),
    .hi_fail(hi_fail), .lo_fail(lo_fail), .hi_warn(hi_warn), .lo_warn(lo_warn),
    .sat_lim(sat_lim), .clr(clr),
    .result(meas_count), .ready(meas_ready), .flags(flags)
  );

  assign evt_fail = flags[EV_FAIL];
  assign evt_warn = flags[EV_WARN];
  assign evt_sat  = flags[EV_SAT];

  assert_cfg_frozen_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    en |=> ($stable(win_len) && $stable(div_code) && $stable(sat_lim)
            && $stable(hi_fail) && $stable(lo_warn)));
  assert_result_within_ceiling_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(meas_ready) |-> (meas_count <= sat_lim));
endmodule

// File: tb/clk_freq_monitor_tb_top.sv
`timescale 1ns/1ps
module clk_freq_monitor_tb_top;
  logic        clk_ref = 1'b0;
  logic        clk_mon = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] meas_count;
  logic        meas_ready, evt_fail, evt_warn, evt_sat;

  int mon_half = 2;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_ref = ~clk_ref;
  initial begin
    #1;
    forever #(mon_half) clk_mon = ~clk_mon;
  end

  clk_freq_monitor dut_i (
    .clk_ref(clk_ref), .clk_mon(clk_mon), .rst_n(rst_n), .en(en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .meas_count(meas_count), .meas_ready(meas_ready),
    .evt_fail(evt_fail), .evt_warn(evt_warn), .evt_sat(evt_sat)
  );

  // window = 8*k reference cycles of 8 ns; monitored period tmon ns; ratio 2^d
  function automatic int exp_count(int k, int tmon, int d);
    return (64 * k) / (tmon * (1 << d));
  endfunction
  function automatic int clamp0(int v);
    return (v < 0) ? 0 : v;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_ref);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
    @(negedge clk_ref);
    cfg_we = 1'b0;
  endtask

  task automatic setup(int k, int tmon, int d, int hf, int lf, int hw, int lw, int sat);
    en = 1'b0;
    cyc(10);
    mon_half = tmon / 2;
    cyc(4);
    wr(0, 8 * k - 1); wr(1, d);
    wr(2, hf); wr(3, lf); wr(4, hw); wr(5, lw); wr(6, sat);
    wr(7, 7);
  endtask

  task automatic run_steady(int k);
    @(negedge clk_ref); en = 1'b1;
    cyc(3 * 8 * k + 30);
  endtask

  initial begin
    int e;
    cyc(3);
    check("R11 reset count", meas_count, 0);
    check("R11 reset ready", meas_ready, 0);
    check("R11 reset flags", {evt_fail, evt_warn, evt_sat}, 0);
    rst_n = 1'b1;
    cyc(3);

    // directed: 256-cycle window, monitor twice the reference, divide by 2
    setup(32, 4, 1, 1000, 0, 1000, 0, 1000);
    @(negedge clk_ref); en = 1'b1;
    cyc(256 + 128);
    check("R10 first window ready", meas_ready, 0);
    check("R10 first window count", meas_count, 0);
    cyc(256 * 2);
    check("R1 steady count", meas_count, 256);
    check("R9 ready set", meas_ready, 1);
    wr(0, 127);  // must be ignored while enabled
    cyc(256 * 3);
    check("R8 window write ignored", meas_count, 256);
    check("R3 count repeats", meas_count, 256);
    @(negedge clk_ref); en = 1'b0;
    cyc(2);
    check("R9 ready drops", meas_ready, 0);
    check("R3 count held after disable", meas_count, 256);

    // divider codes
    for (int d = 0; d < 3; d++) begin
      setup(8, 8, d, 1000, 0, 1000, 0, 1000);
      run_steady(8);
      check($sformatf("R2 divider code %0d", d), meas_count, exp_count(8, 8, d));
    end
    setup(8, 8, 3, 1000, 0, 1000, 0, 1000);
    run_steady(8);
    check("R2 reserved code", meas_count, 64);

    // limit boundaries, E = 64
    e = 64;
    setup(8, 8, 0, e, e, e - 1, 0, 1000);
    run_steady(8);
    check("R4 equal limits no fail", evt_fail, 0);
    check("R5 above high warn", evt_warn, 1);
    check("R6 no sat", evt_sat, 0);
    setup(8, 8, 0, e - 1, 0, 1000, 0, 1000);
    run_steady(8);
    check("R4 above high fail", evt_fail, 1);
    @(negedge clk_ref); en = 1'b0;
    cyc(20);
    check("R7 fail sticky after disable", evt_fail, 1);
    wr(7, 2);
    cyc(2);
    check("R7 clear of other bit keeps fail", evt_fail, 1);
    wr(7, 1);
    cyc(2);
    check("R7 fail cleared", evt_fail, 0);
    setup(8, 8, 0, 1000, e + 1, 1000, e + 1, 1000);
    run_steady(8);
    check("R4 below low fail", evt_fail, 1);
    check("R5 below low warn", evt_warn, 1);
    setup(8, 8, 0, 1000, 0, 1000, 0, e);
    run_steady(8);
    check("R6 ceiling equal count", meas_count, e);
    check("R6 sat flag", evt_sat, 1);
    setup(8, 8, 0, 1000, 0, 1000, 0, e - 5);
    run_steady(8);
    check("R6 clipped count", meas_count, e - 5);
    check("R6 sat flag clipped", evt_sat, 1);
    check("R4 clipped no fail", evt_fail, 0);

    // constrained random
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_c0de);
    end
    for (int t = 0; t < 10; t++) begin
      int k, tm, d, hf, lf, hw, lw, sat, r;
      int tsel;
      k = 2 + int'($urandom_range(14));
      tsel = int'($urandom_range(2));
      tm = (tsel == 0) ? 4 : ((tsel == 1) ? 8 : 16);
      d = int'($urandom_range(2));
      e = exp_count(k, tm, d);
      hf = clamp0(e + int'($urandom_range(6)) - 3);
      lf = clamp0(e + int'($urandom_range(6)) - 3);
      hw = clamp0(e + int'($urandom_range(4)) - 2);
      lw = clamp0(e + int'($urandom_range(4)) - 2);
      sat = clamp0(e + int'($urandom_range(4)) - 2);
      r = (e < sat) ? e : sat;
      setup(k, tm, d, hf, lf, hw, lw, sat);
      run_steady(k);
      check($sformatf("R1 random count t%0d", t), meas_count, r);
      check($sformatf("R4 random fail t%0d", t), evt_fail, (r > hf) || (r < lf));
      check($sformatf("R5 random warn t%0d", t), evt_warn, (r > hw) || (r < lw));
      check($sformatf("R6 random sat t%0d", t), evt_sat, r >= sat);
    end
    en = 1'b0;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_ref);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule